// File: doc/BRIEF.md
# Delay-Line Bring-Up Sequencer

This block takes a sampling delay line from an unknown state to a locked, clock-producing state before any phase sweep starts. One `start` pulse begins a fixed series of register writes. First it turns off clock power-save gating, so the card clock cannot stop while the line is being trained. It then asserts the line's reset and power-down controls. While both are held, it programs a three-bit band code derived from the present card clock frequency. It releases reset and then power-down, and finally enables the line and its output clock.

After the last write the sequencer polls the line's lock flag once per microsecond tick. It reports either a single-cycle `done` when lock is seen or a single-cycle `timeout` after a bounded number of unsuccessful polls. The configuration word is presented as a 32-bit registered output that a neighbouring register bank or the analog macro decodes. Bit positions inside that word are therefore fixed.

Top module: `dll_init_seq`

## Requirements
- R1: After reset `cfg_word` is 0, `pwrsave_en` is 1, and `done` and `timeout` are 0.
- R2: `pwrsave_en` is driven to 0 before the line reset control (cfg bit 30) is set.
- R3: Reset (bit 30) is set before power-down (bit 29) is set, in separate cycles.
- R4: The band code sits in cfg bits 26:24 and changes only while bits 30 and 29 are both 1. Its value is the number of band limits below the frequency, using limits of 112, 125, 137, 150, 162, 175 and 187 MHz. A frequency of 112 MHz or less gives 0, and 200 MHz gives 7. Each limit belongs to the lower band.
- R5: A frequency above 200 MHz, up to the full 32-bit input range, gives band code 0.
- R6: Reset stays set for at least `HOLD_CYC`+1 cycles after power-down is set. Reset is cleared before power-down is cleared.
- R7: Line enable (bit 16) is set after power-down clears, and output clock enable (bit 18) is set after line enable. All other cfg bits stay 0.
- R8: `lock_in` is sampled only in cycles where `us_tick` is 1, and only after bit 18 is set. The first such sample that sees lock gives a one-cycle `done`. This includes lock seen on the final allowed poll, and lock that was already high before polling began.
- R9: After `POLL_LIMIT` ticks without lock, a one-cycle `timeout` is given and `cfg_word` keeps its last written value.
- R10: `start` has no effect while a sequence is running. A pulse during polling neither restarts the sequence nor extends the poll window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a bring-up sequence (taken only when idle) |
| clk_freq_hz | input | 32 | Current card clock frequency in Hz |
| lock_in | input | 1 | Lock flag of the delay line |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| cfg_word | output | 32 | Delay-line configuration word |
| pwrsave_en | output | 1 | Clock power-save gating enable |
| done | output | 1 | One-cycle pulse: lock seen |
| timeout | output | 1 | One-cycle pulse: poll window expired |

## Verification
A wrong sequencer state shows up in the order in which `cfg_word` bits rise and fall. It appears within a cycle or two of the faulty step, for example as a band code written outside the reset window or as bit 18 rising before bit 16. A poll counter that is off by one, or that restarts, moves `done` or `timeout` by a whole tick. That error is seen on the cycle after the final tick. A mis-decoded band appears as a wrong bits 26:24 field once the sequence ends. The sweep walks every band limit and limit+1 to expose it.

// File: rtl/dll_seq_pkg.sv
package dll_seq_pkg;
  localparam int CFG_W     = 32;
  localparam int RST_BIT   = 30;
  localparam int PDN_BIT   = 29;
  localparam int CODE_LSB  = 24;
  localparam int CODE_W    = 3;
  localparam int OUTEN_BIT = 18;
  localparam int EN_BIT    = 16;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PSAVE, ST_SET_RST, ST_SET_PDN, ST_CODE, ST_HOLD,
    ST_CLR_RST, ST_CLR_PDN, ST_EN, ST_OUTEN, ST_POLL
  } seq_st_t;

  // Upper edge (inclusive) of each frequency band, in Hz.
  function automatic longint band_top(input int idx);
    case (idx)
      0: return 64'd112_000_000;
      1: return 64'd125_000_000;
      2: return 64'd137_000_000;
      3: return 64'd150_000_000;
      4: return 64'd162_000_000;
      5: return 64'd175_000_000;
      6: return 64'd187_000_000;
      default: return 64'd200_000_000;
    endcase
  endfunction
endpackage

// File: rtl/dll_band_coder.sv
module dll_band_coder
  import dll_seq_pkg::*;
#(
  parameter int FREQ_W = 32
) (
  input  logic [FREQ_W-1:0] freq_hz,
  output logic [CODE_W-1:0] code
);
  localparam int NBANDS = 1 << CODE_W;

  logic [NBANDS-2:0] above;
  logic              over_top;

  for (genvar k = 0; k < NBANDS - 1; k++) begin : g_lim
    localparam logic [63:0] LIM = 64'(band_top(k));
    assign above[k] = 64'(freq_hz) > LIM;
  end

  localparam logic [63:0] TOP_LIM = 64'(band_top(NBANDS - 1));
  assign over_top = 64'(freq_hz) > TOP_LIM;

  always_comb begin
    code = '0;
    for (int i = 0; i < NBANDS - 1; i++) code = code + CODE_W'(above[i]);
    if (over_top) code = '0;
  end
endmodule

// File: rtl/dll_step_counter.sv
module dll_step_counter #(
  parameter int LIMIT = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  output logic at_last
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt;

  assign at_last = (cnt == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr)          cnt <= '0;
    else if (adv && !at_last) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dll_init_seq.sv
module dll_init_seq
  import dll_seq_pkg::*;
#(
  parameter int   FREQ_W     = 32,
  parameter int   HOLD_CYC   = 4,
  parameter int   POLL_LIMIT = 50,
  parameter logic PSAVE_RST  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [FREQ_W-1:0] clk_freq_hz,
  input  logic              lock_in,
  input  logic              us_tick,
  output logic [CFG_W-1:0]  cfg_word,
  output logic              pwrsave_en,
  output logic              done,
  output logic              timeout
);
  seq_st_t           st;
  logic [CODE_W-1:0] band;
  logic              hold_last;
  logic              poll_last;

  dll_band_coder #(.FREQ_W(FREQ_W)) u_band (
    .freq_hz(clk_freq_hz),
    .code   (band)
  );

  dll_step_counter #(.LIMIT(HOLD_CYC)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .clr    (st != ST_HOLD),
    .adv    (1'b1),
    .at_last(hold_last)
  );

  dll_step_counter #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk    (clk),
    .rst    (rst),
    .clr    (st != ST_POLL),
    .adv    (us_tick),
    .at_last(poll_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cfg_word   <= '0;
      pwrsave_en <= PSAVE_RST;
      done       <= 1'b0;
      timeout    <= 1'b0;
    end else begin
      done    <= 1'b0;
      timeout <= 1'b0;
      case (st)
        ST_IDLE:    if (start) st <= ST_PSAVE;
        ST_PSAVE:   begin pwrsave_en <= 1'b0;        st <= ST_SET_RST; end
        ST_SET_RST: begin cfg_word[RST_BIT] <= 1'b1; st <= ST_SET_PDN; end
        ST_SET_PDN: begin cfg_word[PDN_BIT] <= 1'b1; st <= ST_CODE;    end
        ST_CODE: begin
          cfg_word[CODE_LSB +: CODE_W] <= band;
          st <= ST_HOLD;
        end
        ST_HOLD:    if (hold_last) st <= ST_CLR_RST;
        ST_CLR_RST: begin cfg_word[RST_BIT]   <= 1'b0; st <= ST_CLR_PDN; end
        ST_CLR_PDN: begin cfg_word[PDN_BIT]   <= 1'b0; st <= ST_EN;      end
        ST_EN:      begin cfg_word[EN_BIT]    <= 1'b1; st <= ST_OUTEN;   end
        ST_OUTEN:   begin cfg_word[OUTEN_BIT] <= 1'b1; st <= ST_POLL;    end
        ST_POLL: begin
          if (us_tick) begin
            if (lock_in) begin
              done <= 1'b1;
              st   <= ST_IDLE;
            end else if (poll_last) begin
              timeout <= 1'b1;
              st      <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dll_init_seq_chk.sv
module dll_init_seq_chk
  import dll_seq_pkg::*;
#(
  parameter int HOLD_CYC = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [CFG_W-1:0] cfg_word,
  input logic             pwrsave_en,
  input logic             done,
  input logic             timeout,
  input logic             lock_in,
  input logic             us_tick
);
  localparam logic [CFG_W-1:0] USED =
      (CFG_W'(1) << RST_BIT) | (CFG_W'(1) << PDN_BIT) |
      (CFG_W'(1) << OUTEN_BIT) | (CFG_W'(1) << EN_BIT) |
      (CFG_W'((1 << CODE_W) - 1) << CODE_LSB);

  int held_q;
  always_ff @(posedge clk) begin
    if (rst || !(cfg_word[RST_BIT] && cfg_word[PDN_BIT])) held_q <= 0;
    else if (held_q < 100000) held_q <= held_q + 1;
  end

  p_psave_first_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_word[RST_BIT]) |-> !pwrsave_en);

  p_pdn_after_rst_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_word[PDN_BIT]) |-> $past(cfg_word[RST_BIT]));

  p_code_under_reset_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_word[CODE_LSB +: CODE_W]) |-> (cfg_word[RST_BIT] && cfg_word[PDN_BIT]));

  p_hold_window_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(cfg_word[RST_BIT]) |-> held_q >= HOLD_CYC + 1);

  p_rst_clears_first_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(cfg_word[PDN_BIT]) |-> !cfg_word[RST_BIT]);

  p_outen_needs_en_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_word[OUTEN_BIT] |-> cfg_word[EN_BIT]);

  p_spare_bits_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_word & ~USED) == '0);

  p_done_on_tick_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(us_tick) && $past(lock_in) && !timeout));

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_timeout_keeps_cfg_r9: assert property (@(posedge clk) disable iff (rst)
    timeout |-> ($stable(cfg_word) && $past(us_tick) && !$past(lock_in)));
endmodule

bind dll_init_seq dll_init_seq_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (.*);

// File: tb/test_dll_init_seq.sv
module test_dll_init_seq;
  localparam int HOLD = 4;
  localparam int PL   = 50;
  localparam int TDIV = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] clk_freq_hz = '0;
  logic        lock_in = 1'b0;
  logic        us_tick = 1'b0;
  logic [31:0] cfg_word;
  logic        pwrsave_en, done, timeout;

  int errs = 0, checks = 0, div = 0, poll_ticks = 0;
  bit in_poll = 1'b0;

  always #4 clk = ~clk;

  dll_init_seq #(.HOLD_CYC(HOLD), .POLL_LIMIT(PL)) i_dll_init_seq (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic drive_tick();
    div = (div == TDIV - 1) ? 0 : div + 1;
    us_tick = (div == TDIV - 1);
    if (in_poll && us_tick) poll_ticks++;
  endtask

  function automatic int exp_code(input longint f);
    if (f > 64'd200_000_000) return 0;
    for (int k = 0; k < 8; k++)
      if (f <= longint'(100 + (125 * (k + 1)) / 10) * 1_000_000) return k;
    return 0;
  endfunction

  // k: lock raised after k poll ticks (-1: high from start, >= PL: never)
  task automatic run_seq(input longint f, input int k, input int restart_at);
    int e_ps = -1, e_rr = -1, e_pr = -1, e_rf = -1, e_pf = -1, e_en = -1, e_oe = -1;
    int res = 0;
    bit restarted = 1'b0;
    logic [31:0] prev;
    logic [31:0] exp_word;
    int code;
    rst = 1'b1; lock_in = 1'b0; in_poll = 1'b0; poll_ticks = 0;
    step(); step();
    rst = 1'b0;
    step();
    chk(cfg_word == 0 && pwrsave_en && !done && !timeout, "R1 reset state",
        longint'({pwrsave_en, done, timeout, cfg_word}), longint'({3'b100, 32'd0}));
    clk_freq_hz = f[31:0];
    lock_in = (k < 0);
    start = 1'b1;
    prev = cfg_word;
    for (int n = 0; n < 3000; n++) begin
      step();
      start = 1'b0;
      if (!pwrsave_en && e_ps < 0) e_ps = n;
      if (cfg_word[30] && !prev[30]) e_rr = n;
      if (cfg_word[29] && !prev[29]) e_pr = n;
      if (!cfg_word[30] && prev[30]) e_rf = n;
      if (!cfg_word[29] && prev[29]) e_pf = n;
      if (cfg_word[16] && !prev[16]) e_en = n;
      if (cfg_word[18] && !prev[18]) begin e_oe = n; in_poll = 1'b1; end
      if (done)    begin res = 1; break; end
      if (timeout) begin res = 2; break; end
      prev = cfg_word;
      if (restart_at >= 0 && in_poll && !restarted && poll_ticks == restart_at) begin
        start = 1'b1; restarted = 1'b1;
      end
      if (k >= 0 && in_poll && poll_ticks == k) lock_in = 1'b1;
      drive_tick();
    end
    start = 1'b0;
    chk(res != 0, "R8 watchdog: no done or timeout", res, 1);
    code = exp_code(f);
    exp_word = (32'(code) << 24) | (32'd1 << 16) | (32'd1 << 18);
    chk(e_ps >= 0 && e_ps < e_rr, "R2 power-save cleared before reset", e_ps, e_rr - 1);
    chk(e_rr >= 0 && e_rr < e_pr, "R3 reset before power-down", e_rr, e_pr - 1);
    chk(e_rf - e_pr >= HOLD + 1 && e_pf > e_rf, "R6 hold window and release order",
        e_rf - e_pr, HOLD + 1);
    chk(e_en > e_pf && e_oe > e_en, "R7 enable after power-down, outen after enable",
        e_oe - e_en, 1);
    chk(cfg_word[26:24] == 3'(code), (f > 200_000_000) ? "R5 band code above top" :
        "R4 band code", cfg_word[26:24], code);
    chk(cfg_word == exp_word, "R7 final cfg word", cfg_word, exp_word);
    if (k < PL) begin
      chk(res == 1 && poll_ticks == ((k < 0) ? 1 : k + 1), "R8 done on lock tick",
          poll_ticks, (k < 0) ? 1 : k + 1);
    end else begin
      chk(res == 2 && poll_ticks == PL,
          (restart_at >= 0) ? "R10 start ignored during polling" : "R9 timeout after limit",
          poll_ticks, PL);
    end
    step();
    chk(!done && !timeout && cfg_word == exp_word, "R9 pulse ends and cfg held",
        longint'({done, timeout}), 0);
    in_poll = 1'b0;
  endtask

  initial begin
    for (int b = 0; b < 8; b++) begin
      longint lim = longint'(100 + (125 * (b + 1)) / 10) * 1_000_000;
      run_seq(lim, 0, -1);
      run_seq(lim + 1, 0, -1);
    end
    run_seq(0, 0, -1);
    run_seq(100_000_000, 0, -1);
    run_seq(400_000_000, 2, -1);
    run_seq(64'hFFFF_FFFF, 0, -1);
    run_seq(150_000_000, -1, -1);
    run_seq(150_000_000, 7, -1);
    run_seq(150_000_000, PL - 1, -1);
    run_seq(150_000_000, PL, -1);
    run_seq(180_000_000, 1000, 20);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errs++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule